// File: doc/BRIEF.md
# Load-Use and Exclusive-Access Interlock

This unit decides, every cycle, whether the instruction waiting in stage 2 of a short in-order pipeline may advance. Operands are read in stage 2. Results of loads, single-cycle multiplies, load-reserved accesses and atomic memory operations only exist at the end of stage 3. A stage-2 instruction that needs such a result must therefore wait one cycle. The unit also keeps back-to-back exclusive bus accesses apart, because the bus cannot overlap them.

The unit keeps its own small record of the instruction now in stage 3: valid, class, destination index and write flag. It fills this record from the stage-2 fields whenever the pipeline advances. While a bubble is requested, the record receives an empty slot. The surrounding pipeline holds the PC and stage 2 while `stall_front` is high, and feeds a NOP with no side effects into stage 3 while `bubble_s3` is high. The pipeline is assumed to advance on every cycle in which this unit does not stall it.

Top module: `ilk_loaduse_interlock`

## Requirements
- R1: `s2_cls` uses these codes: 0 ALU, 1 load, 2 store, 3 branch, 4 multiply, 5 load-reserved, 6 store-conditional, 7 atomic. A stall lasting exactly one cycle is raised in the following case: an accepted load that writes register r is followed by a valid instruction whose first source (rs1) is used and equals r.
- R2: The second source (rs2) of a store (code 2) or store-conditional (code 6) is store data. A match on it alone never stalls.
- R3: The base register (rs1) of a store matching a late destination stalls like any other operand.
- R4: Multiply, load-reserved and atomic instructions are late producers just like loads. A dependent rs1 or rs2 of any other consumer class stalls.
- R5: A destination index of 0 never causes a stall.
- R6: A source index counts only when its use flag (`s2_rs1_used`, `s2_rs2_used`) is high.
- R7: A stall lasts one cycle. `bubble_s3` equals `stall_front`, stage 3 then holds an empty slot, and the held instruction proceeds on the next cycle without a further stall.
- R8: A valid load-reserved, store-conditional or atomic instruction directly behind a load-reserved or store-conditional stalls one cycle, whatever its register indices.
- R9: ALU and store-conditional producers, stores, branches, and instructions with `s2_rd_we` low never cause a register-dependency stall.
- R10: With `s2_valid` low there is no stall, and the empty slot that follows causes no hazard.
- R11: During and directly after reset the stage-3 record is empty and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s2_valid | input | 1 | Stage 2 holds a real instruction |
| s2_cls | input | 3 | Stage-2 instruction class code |
| s2_rd | input | AW | Stage-2 destination index |
| s2_rd_we | input | 1 | Stage-2 instruction writes its destination |
| s2_rs1 | input | AW | First source index (address base for memory ops) |
| s2_rs1_used | input | 1 | First source is read |
| s2_rs2 | input | AW | Second source index (store data for stores) |
| s2_rs2_used | input | 1 | Second source is read |
| stall_front | output | 1 | Hold PC and stage 2 this cycle |
| bubble_s3 | output | 1 | Send a NOP into stage 3 this cycle |

## Verification
The hardest case to reach is a held instruction after its bubble. Its stage-2 fields still match the register they matched a cycle earlier, yet it must now pass, because stage 3 holds an empty slot rather than the producer. The stimulus table therefore repeats every stalled vector on the next row and expects no stall there. It also places an invalid slot directly in front of a load-reserved instruction, so that the empty stage-3 record meets an exclusive consumer.

// File: rtl/ilk_pkg.sv
// Shared types for the load-use interlock.
// Assumes a three-bit class code fixed by the decoder.
package ilk_pkg;

    typedef enum logic [2:0] {
        ILK_ALU    = 3'd0,
        ILK_LOAD   = 3'd1,
        ILK_STORE  = 3'd2,
        ILK_BRANCH = 3'd3,
        ILK_MUL    = 3'd4,
        ILK_LR     = 3'd5,
        ILK_SC     = 3'd6,
        ILK_AMO    = 3'd7
    } ilk_cls_e;

    // Class whose result only exists at the end of stage 3
    function automatic logic ilk_is_late(input ilk_cls_e c);
        return (c == ILK_LOAD) || (c == ILK_MUL) || (c == ILK_LR) || (c == ILK_AMO);
    endfunction

    // Class whose second source is store data consumed in stage 3
    function automatic logic ilk_rs2_is_data(input ilk_cls_e c);
        return (c == ILK_STORE) || (c == ILK_SC);
    endfunction

    // Exclusive bus access that must not follow another one back to back
    function automatic logic ilk_is_excl(input ilk_cls_e c);
        return (c == ILK_LR) || (c == ILK_SC);
    endfunction

endpackage

// File: rtl/ilk_s3_track.sv
// Stage-3 record: holds what the interlock needs to know about the
// instruction now in stage 3. Assumes the pipeline advances every cycle
// unless bubble_i is high, in which case stage 3 receives a NOP.
module ilk_s3_track
    import ilk_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bubble_i,
    input  logic          s2_valid_i,
    input  ilk_cls_e      s2_cls_i,
    input  logic [AW-1:0] s2_rd_i,
    input  logic          s2_rd_we_i,
    output logic          s3_valid_o,
    output ilk_cls_e      s3_cls_o,
    output logic [AW-1:0] s3_rd_o,
    output logic          s3_rd_we_o
);

    // Capture stage 2 on advance, load an empty slot on a bubble
    always_ff @(posedge clk) begin
        if (!rst_n || bubble_i || !s2_valid_i) begin
            s3_valid_o <= 1'b0;
            s3_cls_o   <= ILK_ALU;
            s3_rd_o    <= '0;
            s3_rd_we_o <= 1'b0;
        end else begin
            s3_valid_o <= 1'b1;
            s3_cls_o   <= s2_cls_i;
            s3_rd_o    <= s2_rd_i;
            s3_rd_we_o <= s2_rd_we_i;
        end
    end

endmodule

// File: rtl/ilk_src_match.sv
// One source-operand comparator: flags a dependency of a stage-2 operand
// on a late result in stage 3. Assumes the caller has already qualified
// the producer (valid, late class, writes a non-zero register).
module ilk_src_match #(
    parameter int AW = 5
) (
    input  logic          late_wr_i,
    input  logic [AW-1:0] late_rd_i,
    input  logic [AW-1:0] src_i,
    input  logic          used_i,
    input  logic          exempt_i,
    output logic          hit_o
);

    // Match only when the operand is read in stage 2
    always_comb begin
        hit_o = late_wr_i && used_i && !exempt_i && (src_i == late_rd_i);
    end

endmodule

// File: rtl/ilk_excl_guard.sv
// Exclusive-access guard: flags an exclusive or atomic access that would
// follow an exclusive access in stage 3 without a gap on the bus.
module ilk_excl_guard
    import ilk_pkg::*;
(
    input  logic     s3_valid_i,
    input  ilk_cls_e s3_cls_i,
    input  ilk_cls_e s2_cls_i,
    output logic     excl_hit_o
);

    // Any load-reserved, store-conditional or atomic behind LR/SC collides
    always_comb begin
        excl_hit_o = s3_valid_i && ilk_is_excl(s3_cls_i) &&
                     (ilk_is_excl(s2_cls_i) || (s2_cls_i == ILK_AMO));
    end

endmodule

// File: rtl/ilk_loaduse_interlock.sv
// Load-use and exclusive-access interlock for a short in-order pipeline.
// Compares stage-2 sources against the late-result destination tracked for
// stage 3 and requests a one-cycle bubble when needed. Assumes operands are
// read in stage 2, store data in stage 3, and no other stall source exists.
module ilk_loaduse_interlock
    import ilk_pkg::*;
#(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s2_valid,
    input  logic [2:0]    s2_cls,
    input  logic [AW-1:0] s2_rd,
    input  logic          s2_rd_we,
    input  logic [AW-1:0] s2_rs1,
    input  logic          s2_rs1_used,
    input  logic [AW-1:0] s2_rs2,
    input  logic          s2_rs2_used,
    output logic          stall_front,
    output logic          bubble_s3
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    ilk_cls_e      cls2;
    logic          s3_valid;
    ilk_cls_e      s3_cls;
    logic [AW-1:0] s3_rd;
    logic          s3_rd_we;
    logic          late_wr;
    logic          excl_hit;
    logic          need_bubble;
    logic [AW-1:0] src_idx  [NSRC];
    logic          src_used [NSRC];
    logic [NSRC-1:0] src_hit;

    // Decode the class field into the shared type
    always_comb cls2 = ilk_cls_e'(s2_cls);

    ilk_s3_track #(.AW(AW)) u_s3 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bubble_i   (need_bubble),
        .s2_valid_i (s2_valid),
        .s2_cls_i   (cls2),
        .s2_rd_i    (s2_rd),
        .s2_rd_we_i (s2_rd_we),
        .s3_valid_o (s3_valid),
        .s3_cls_o   (s3_cls),
        .s3_rd_o    (s3_rd),
        .s3_rd_we_o (s3_rd_we)
    );

    // Qualify stage 3 as a producer of a late, non-zero result
    always_comb begin
        late_wr = s3_valid && s3_rd_we && ilk_is_late(s3_cls) && (s3_rd != ZERO_REG);
    end

    // Gather operand fields so one comparator per source can be generated
    always_comb begin
        src_idx[0]  = s2_rs1;
        src_used[0] = s2_rs1_used;
        src_idx[1]  = s2_rs2;
        src_used[1] = s2_rs2_used;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic exempt;
        // Only the second operand of a store-type access may be store data
        always_comb exempt = (g == 1) && ilk_rs2_is_data(cls2);

        ilk_src_match #(.AW(AW)) u_match (
            .late_wr_i (late_wr),
            .late_rd_i (s3_rd),
            .src_i     (src_idx[g]),
            .used_i    (src_used[g]),
            .exempt_i  (exempt),
            .hit_o     (src_hit[g])
        );
    end

    ilk_excl_guard u_excl (
        .s3_valid_i (s3_valid),
        .s3_cls_i   (s3_cls),
        .s2_cls_i   (cls2),
        .excl_hit_o (excl_hit)
    );

    // Combine hazard sources for a valid stage-2 instruction
    always_comb begin
        need_bubble = s2_valid && ((|src_hit) || excl_hit);
        stall_front = need_bubble;
        bubble_s3   = need_bubble;
    end

endmodule

// File: rtl/ilk_interlock_chk.sv
// Checker for the interlock: relates stage-2 inputs of consecutive cycles
// to the stall output. Attached to the top module by bind below.
module ilk_interlock_chk
    import ilk_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s2_valid,
    input logic [2:0]    s2_cls,
    input logic [AW-1:0] s2_rd,
    input logic          s2_rd_we,
    input logic [AW-1:0] s2_rs1,
    input logic          s2_rs1_used,
    input logic [AW-1:0] s2_rs2,
    input logic          s2_rs2_used,
    input logic          stall_front,
    input logic          bubble_s3
);

    logic seen;

    // Mark the cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(s2_valid && !stall_front && s2_cls == ILK_LOAD && s2_rd_we && s2_rd != '0)
              && s2_valid && s2_rs1_used && s2_rs1 == $past(s2_rd)) |-> stall_front); // R1

    AST_STORE_DATA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(s2_valid && !stall_front && s2_cls == ILK_LOAD)
              && s2_cls == ILK_STORE && !s2_rs1_used) |-> !stall_front); // R2

    AST_X0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!stall_front && s2_rd == '0 &&
              (s2_cls == ILK_LOAD || s2_cls == ILK_MUL || s2_cls == ILK_AMO))) |-> !stall_front); // R5

    AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_front |=> !stall_front); // R7

    AST_EXCL_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(s2_valid && !stall_front && (s2_cls == ILK_LR || s2_cls == ILK_SC))
              && s2_valid && (s2_cls == ILK_LR || s2_cls == ILK_SC || s2_cls == ILK_AMO))
              |-> (stall_front && bubble_s3)); // R8

    AST_EARLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!stall_front &&
              (s2_cls == ILK_ALU || s2_cls == ILK_STORE || s2_cls == ILK_BRANCH))) |-> !stall_front); // R9

    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_valid |-> !bubble_s3); // R10

endmodule

bind ilk_loaduse_interlock ilk_interlock_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s2_valid    (s2_valid),
    .s2_cls      (s2_cls),
    .s2_rd       (s2_rd),
    .s2_rd_we    (s2_rd_we),
    .s2_rs1      (s2_rs1),
    .s2_rs1_used (s2_rs1_used),
    .s2_rs2      (s2_rs2),
    .s2_rs2_used (s2_rs2_used),
    .stall_front (stall_front),
    .bubble_s3   (bubble_s3)
);

// File: tb/tb_ilk_loaduse_interlock.sv
// Bench: walks a vector table of stage-2 instructions, one per cycle,
// then runs directed reset cases. Class codes: 0 ALU 1 LD 2 ST 3 BR 4 MUL 5 LR 6 SC 7 AMO.
module tb_ilk_loaduse_interlock;

    localparam int AW = 5;
    localparam int NV = 26;
    // {valid, cls[2:0], rd[4:0], we, rs1[4:0], u1, rs2[4:0], u2, exp_stall}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1,3'd1,5'd5, 1'b1,5'd1, 1'b1,5'd0, 1'b0,1'b0}, // load x5
        {1'b1,3'd0,5'd7, 1'b1,5'd5, 1'b1,5'd0, 1'b0,1'b1}, // R1 alu uses x5
        {1'b1,3'd0,5'd7, 1'b1,5'd5, 1'b1,5'd0, 1'b0,1'b0}, // R7 held, passes
        {1'b1,3'd1,5'd6, 1'b1,5'd7, 1'b1,5'd0, 1'b0,1'b0}, // R9 alu producer
        {1'b1,3'd2,5'd0, 1'b0,5'd2, 1'b1,5'd6, 1'b1,1'b0}, // R2 store data x6
        {1'b1,3'd1,5'd8, 1'b1,5'd3, 1'b1,5'd0, 1'b0,1'b0}, // R9 after store
        {1'b1,3'd2,5'd0, 1'b0,5'd8, 1'b1,5'd9, 1'b1,1'b1}, // R3 store base x8
        {1'b1,3'd2,5'd0, 1'b0,5'd8, 1'b1,5'd9, 1'b1,1'b0}, // R7
        {1'b1,3'd4,5'd10,1'b1,5'd1, 1'b1,5'd2, 1'b1,1'b0}, // mul x10
        {1'b1,3'd3,5'd0, 1'b0,5'd4, 1'b1,5'd10,1'b1,1'b1}, // R4 branch rs2
        {1'b1,3'd3,5'd0, 1'b0,5'd4, 1'b1,5'd10,1'b1,1'b0}, // R7
        {1'b1,3'd1,5'd0, 1'b1,5'd1, 1'b1,5'd0, 1'b0,1'b0}, // R9 after branch
        {1'b1,3'd0,5'd3, 1'b1,5'd0, 1'b1,5'd0, 1'b1,1'b0}, // R5 x0
        {1'b1,3'd1,5'd11,1'b1,5'd1, 1'b1,5'd0, 1'b0,1'b0}, // load x11
        {1'b1,3'd0,5'd12,1'b1,5'd11,1'b0,5'd12,1'b1,1'b0}, // R6 unused rs1
        {1'b1,3'd5,5'd13,1'b1,5'd1, 1'b1,5'd0, 1'b0,1'b0}, // lr
        {1'b1,3'd6,5'd14,1'b1,5'd20,1'b1,5'd21,1'b1,1'b1}, // R8 sc after lr
        {1'b1,3'd6,5'd14,1'b1,5'd20,1'b1,5'd21,1'b1,1'b0}, // R7
        {1'b1,3'd7,5'd15,1'b1,5'd22,1'b1,5'd23,1'b1,1'b1}, // R8 amo after sc
        {1'b1,3'd7,5'd15,1'b1,5'd22,1'b1,5'd23,1'b1,1'b0}, // R7
        {1'b1,3'd0,5'd16,1'b1,5'd15,1'b1,5'd0, 1'b0,1'b1}, // R4 amo result
        {1'b1,3'd0,5'd16,1'b1,5'd15,1'b1,5'd0, 1'b0,1'b0}, // R7
        {1'b0,3'd5,5'd16,1'b1,5'd16,1'b1,5'd0, 1'b0,1'b0}, // R10 invalid
        {1'b1,3'd5,5'd17,1'b1,5'd16,1'b1,5'd0, 1'b0,1'b0}, // R10 lr after gap
        {1'b1,3'd0,5'd18,1'b1,5'd1, 1'b1,5'd17,1'b1,1'b1}, // R4 lr result rs2
        {1'b1,3'd0,5'd18,1'b1,5'd1, 1'b1,5'd17,1'b1,1'b0}  // R7
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          s2_valid;
    logic [2:0]    s2_cls;
    logic [AW-1:0] s2_rd;
    logic          s2_rd_we;
    logic [AW-1:0] s2_rs1;
    logic          s2_rs1_used;
    logic [AW-1:0] s2_rs2;
    logic          s2_rs2_used;
    logic          stall_front;
    logic          bubble_s3;
    int            checks = 0;
    int            errors = 0;
    logic          done = 1'b0;

    always #10 clk = ~clk;

    ilk_loaduse_interlock #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_cls(s2_cls),
        .s2_rd(s2_rd), .s2_rd_we(s2_rd_we), .s2_rs1(s2_rs1),
        .s2_rs1_used(s2_rs1_used), .s2_rs2(s2_rs2), .s2_rs2_used(s2_rs2_used),
        .stall_front(stall_front), .bubble_s3(bubble_s3)
    );

    // Compare both outputs against the expected stall
    task automatic check(input logic exp, input string req);
        checks++;
        if (stall_front !== exp || bubble_s3 !== exp) begin
            errors++;
            $display("FAIL %s: stall=%b bubble=%b expected %b", req, stall_front, bubble_s3, exp);
        end
    endtask

    // Drive one stage-2 vector after the falling edge
    task automatic drive(input logic [22:0] v);
        @(negedge clk);
        {s2_valid, s2_cls, s2_rd, s2_rd_we, s2_rs1, s2_rs1_used, s2_rs2, s2_rs2_used} = v[22:1];
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        {s2_valid, s2_cls, s2_rd, s2_rd_we, s2_rs1, s2_rs1_used, s2_rs2, s2_rs2_used} = '0;
        // R11: a pending dependency presented during reset must not stall
        drive({1'b1,3'd1,5'd5,1'b1,5'd5,1'b1,5'd0,1'b0,1'b0});
        drive({1'b1,3'd0,5'd1,1'b1,5'd5,1'b1,5'd0,1'b0,1'b0});
        check(1'b0, "R11 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1'b0, "R11 first cycle after reset");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check(VEC[i][0], $sformatf("vector %0d", i));
        end

        // R11: reset between a load and its consumer clears the record
        drive({1'b1,3'd1,5'd9,1'b1,5'd1,1'b1,5'd0,1'b0,1'b0});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        {s2_valid, s2_cls, s2_rd, s2_rd_we, s2_rs1, s2_rs1_used, s2_rs2, s2_rs2_used} =
            {1'b1,3'd0,5'd2,1'b1,5'd9,1'b1,5'd0,1'b0};
        #1;
        check(1'b0, "R11 record cleared by reset");

        // R9: load without a destination write never stalls its user
        drive({1'b1,3'd1,5'd12,1'b0,5'd1,1'b1,5'd0,1'b0,1'b0});
        drive({1'b1,3'd0,5'd2,1'b1,5'd12,1'b1,5'd0,1'b0,1'b0});
        check(1'b0, "R9 no destination write");

        // R2: store-conditional data operand is also exempt
        drive({1'b1,3'd4,5'd13,1'b1,5'd1,1'b1,5'd0,1'b0,1'b0});
        drive({1'b1,3'd6,5'd2,1'b1,5'd3,1'b1,5'd13,1'b1,1'b0});
        check(1'b0, "R2 sc data operand");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule